// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block gathers the interrupt conditions of a serial port into one interrupt request line and one status code. The code names the single most urgent condition that is both pending and enabled. Lower conditions stay hidden behind a higher one until the higher one is serviced. The detectors for framing and line faults, receive levels, timeouts and modem pins sit outside the block and present their conditions as levels.

Two conditions are held as flags inside the block:

- The transmit-holding-empty flag is armed by reset and by each rising edge of the transmitter's empty indication. It is dropped by a status read that reports it, or by a write to the holding register.
- The special-character flag is armed by a one-cycle match pulse. It is dropped by a status read that reports it.

The encoder is combinational over these flags and the level inputs. Removing one condition therefore reveals the next one in the same cycle.

Top module: `uart_irq_prio`

## Requirements
- R1: `irqOut` is high exactly when at least one enabled condition is pending. When none is pending, `irqCode` is 0.
- R2: Enable bit 0 gates receive-ready and receive-timeout. Bit 1 gates transmit-empty. Bit 2 gates line status and special character. Bit 3 gates modem change and CTS/RTS change. A condition whose enable bit is clear has no effect on either output.
- R3: Codes, from highest priority to lowest: line status 1, receive-ready 2, receive-timeout 3, transmit-empty 4, modem change 5, special character 6, CTS/RTS change 7. `irqCode` shows only the highest enabled pending one.
- R4: Receive-ready and receive-timeout form one priority level under enable bit 0. When both are pending, code 2 is shown. A timeout alone shows code 3.
- R5: The transmit-empty flag is set by reset. If enable bit 1 is set after reset, code 4 appears without any transmitter event.
- R6: A `statusRd` pulse clears the transmit-empty flag from the next cycle on, but only while `irqCode` is 4. A read while another code is shown leaves the flag set.
- R7: A `thrWr` pulse clears the transmit-empty flag from the next cycle on.
- R8: A rising edge on `txEmpty` sets the transmit-empty flag. The code shows it one cycle after the edge is sampled.
- R9: A `specialHit` pulse latches the special-character flag, visible the next cycle. The flag holds until a `statusRd` while `irqCode` is 6.
- R10: The CTS/RTS change (code 7) is shown only when no other enabled condition is pending.
- R11: Changes on the level inputs and on `irqEn` reach `irqOut` and `irqCode` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqEn | input | 4 | Group enables (see R2) |
| lineErr | input | 1 | Line status condition pending |
| rxReady | input | 1 | Receive data at or above trigger level |
| rxTimeout | input | 1 | Receive timeout pending |
| txEmpty | input | 1 | Transmit holding register empty (level) |
| modemChg | input | 1 | Modem input change pending |
| specialHit | input | 1 | One-cycle special-character match pulse |
| flowChg | input | 1 | CTS/RTS change pending |
| statusRd | input | 1 | Status register read strobe |
| thrWr | input | 1 | Transmit holding register write strobe |
| irqOut | output | 1 | Interrupt request |
| irqCode | output | 3 | Highest pending condition code, 0 for none |

## Verification
The bench builds the block with its default parameter, so the transmit-empty flag is armed by reset. This brings the after-reset transmit interrupt and its clearing by a status read within reach.

Stimulus layers conditions so that every priority boundary is crossed, including both members of the shared receive level and a CTS/RTS change hidden behind a latched special character. It also covers status reads that land on a code other than the flag's own, which must not disturb that flag.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int SRC_NUM = 7;
  localparam int CODE_W  = $clog2(SRC_NUM + 1);
  localparam int EN_W    = 4;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 0,
    CODE_LINE  = 1,
    CODE_RXRDY = 2,
    CODE_RXTO  = 3,
    CODE_TXE   = 4,
    CODE_MODEM = 5,
    CODE_SPCHR = 6,
    CODE_FLOW  = 7
  } irqCode_t;

  typedef struct packed {
    logic setTx;
    logic clrTx;
    logic setSpc;
    logic clrSpc;
  } flagStb_t;

  // source index (0 = highest priority) -> enable group
  function automatic int srcGroup(input int idx);
    case (idx)
      0:       return EN_LINE;
      1, 2:    return EN_RX;
      3:       return EN_TX;
      4:       return EN_MODEM;
      5:       return EN_LINE;
      default: return EN_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEmpty,
  input  logic              thrWr,
  input  logic              specialHit,
  input  logic              statusRd,
  input  logic [CODE_W-1:0] curCode,
  output flagStb_t          stb
);
  logic txEmptyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txEmptyQ <= 1'b1;
    else       txEmptyQ <= txEmpty;
  end

  always_comb begin
    stb.setTx  = txEmpty & ~txEmptyQ;
    stb.clrTx  = thrWr | (statusRd && (curCode == CODE_TXE));
    stb.setSpc = specialHit;
    stb.clrSpc = statusRd && (curCode == CODE_SPCHR);
  end

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (thrWr && !stb.setTx) |=> (curCode != CODE_TXE)); // R7
endmodule

// File: rtl/uirq_path.sv
module uirq_path
  import uirq_pkg::*;
#(
  parameter bit TX_PEND_AT_RESET = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  flagStb_t          stb,
  input  logic [EN_W-1:0]   irqEn,
  input  logic              lineErr,
  input  logic              rxReady,
  input  logic              rxTimeout,
  input  logic              modemChg,
  input  logic              flowChg,
  output logic              irqOut,
  output logic [CODE_W-1:0] irqCode
);
  logic txPend;
  logic spcPend;
  logic [SRC_NUM-1:0] rawSrc;
  logic [SRC_NUM-1:0] gatedSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txPend <= TX_PEND_AT_RESET;
    else if (stb.setTx) txPend <= 1'b1;
    else if (stb.clrTx) txPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           spcPend <= 1'b0;
    else if (stb.setSpc) spcPend <= 1'b1;
    else if (stb.clrSpc) spcPend <= 1'b0;
  end

  assign rawSrc = {flowChg, spcPend, modemChg, txPend, rxTimeout, rxReady, lineErr};

  for (genvar g = 0; g < SRC_NUM; g++) begin : gen_gate
    localparam int GRP = srcGroup(g);
    assign gatedSrc[g] = rawSrc[g] & irqEn[GRP];
  end

  always_comb begin
    irqCode = CODE_NONE;
    for (int i = SRC_NUM - 1; i >= 0; i--) begin
      if (gatedSrc[i]) irqCode = CODE_W'(i + 1);
    end
  end

  assign irqOut = |gatedSrc;

  AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (irqCode != CODE_NONE)); // R1
  AST_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == '0) |-> !irqOut); // R2
  AST_RX_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn[EN_RX] && rxReady && !(irqEn[EN_LINE] && lineErr)) |-> (irqCode == CODE_RXRDY)); // R4
  AST_TX_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (TX_PEND_AT_RESET && !$past(rstN)) |-> txPend); // R5
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrTx && !stb.setTx) |=> !txPend); // R6
  AST_SPC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (spcPend && !stb.clrSpc) |=> spcPend); // R9
  AST_FLOW_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (irqCode == CODE_FLOW) |-> (!(irqEn[EN_LINE] && lineErr) &&
      !(irqEn[EN_RX] && (rxReady || rxTimeout)) && !(irqEn[EN_MODEM] && modemChg))); // R10
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uirq_pkg::*;
#(
  parameter bit TX_PEND_AT_RESET = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [EN_W-1:0]   irqEn,
  input  logic              lineErr,
  input  logic              rxReady,
  input  logic              rxTimeout,
  input  logic              txEmpty,
  input  logic              modemChg,
  input  logic              specialHit,
  input  logic              flowChg,
  input  logic              statusRd,
  input  logic              thrWr,
  output logic              irqOut,
  output logic [CODE_W-1:0] irqCode
);
  flagStb_t stb;

  uirq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEmpty    (txEmpty),
    .thrWr      (thrWr),
    .specialHit (specialHit),
    .statusRd   (statusRd),
    .curCode    (irqCode),
    .stb        (stb)
  );

  uirq_path #(.TX_PEND_AT_RESET(TX_PEND_AT_RESET)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .irqEn     (irqEn),
    .lineErr   (lineErr),
    .rxReady   (rxReady),
    .rxTimeout (rxTimeout),
    .modemChg  (modemChg),
    .flowChg   (flowChg),
    .irqOut    (irqOut),
    .irqCode   (irqCode)
  );
endmodule

// File: tb/test_uart_irq_prio.sv
`timescale 1ns/1ps
module test_uart_irq_prio;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] irqEn;
  logic       lineErr, rxReady, rxTimeout, txEmpty, modemChg, specialHit, flowChg;
  logic       statusRd, thrWr;
  logic       irqOut;
  logic [2:0] irqCode;

  typedef struct {
    string      req;
    logic       expIrq;
    logic [2:0] expCode;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_irq_prio i_uart_irq_prio (
    .clk(clk), .rstN(rstN), .irqEn(irqEn), .lineErr(lineErr), .rxReady(rxReady),
    .rxTimeout(rxTimeout), .txEmpty(txEmpty), .modemChg(modemChg),
    .specialHit(specialHit), .flowChg(flowChg), .statusRd(statusRd), .thrWr(thrWr),
    .irqOut(irqOut), .irqCode(irqCode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expectNow(input string req, input logic eIrq, input logic [2:0] eCode);
    expItem_t it;
    it.req = req; it.expIrq = eIrq; it.expCode = eCode;
    expQ.push_back(it);
  endtask

  // monitor: compares a little after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (irqOut !== it.expIrq || irqCode !== it.expCode) begin
          errors++;
          $display("FAIL %s: irq=%0b code=%0d expected irq=%0b code=%0d",
                   it.req, irqOut, irqCode, it.expIrq, it.expCode);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqEn = 4'b0000; lineErr = 0; rxReady = 0; rxTimeout = 0;
    txEmpty = 1; modemChg = 0; specialHit = 0; flowChg = 0; statusRd = 0; thrWr = 0;
    repeat (2) tick();
    expectNow("R1 in reset", 0, 3'd0);
    tick(); rstN = 1'b1;
    expectNow("R1 after reset, enables off", 0, 3'd0);
    tick(); irqEn = 4'b0010;
    expectNow("R5 tx after reset", 1, 3'd4);
    tick(); lineErr = 1;
    expectNow("R2 line masked by enable", 1, 3'd4);
    tick(); irqEn = 4'b0111;
    expectNow("R3 line above tx", 1, 3'd1);
    tick(); statusRd = 1;
    expectNow("R6 read on line code", 1, 3'd1);
    tick(); statusRd = 0; lineErr = 0;
    expectNow("R6 tx kept after foreign read", 1, 3'd4);
    tick(); rxTimeout = 1;
    expectNow("R4 timeout alone", 1, 3'd3);
    tick(); rxReady = 1;
    expectNow("R4 ready wins in shared level", 1, 3'd2);
    tick(); rxReady = 0; rxTimeout = 0;
    expectNow("R11 same-cycle fall back", 1, 3'd4);
    tick(); statusRd = 1;
    expectNow("R6 read on tx code", 1, 3'd4);
    tick(); statusRd = 0;
    expectNow("R6 tx cleared by read", 0, 3'd0);
    tick(); txEmpty = 0;
    expectNow("R8 empty low", 0, 3'd0);
    tick(); txEmpty = 1;
    expectNow("R8 edge not yet visible", 0, 3'd0);
    tick();
    expectNow("R8 tx re-armed", 1, 3'd4);
    tick(); thrWr = 1;
    expectNow("R7 write cycle", 1, 3'd4);
    tick(); thrWr = 0;
    expectNow("R7 tx cleared by write", 0, 3'd0);
    tick(); irqEn = 4'b1111; specialHit = 1;
    expectNow("R9 pulse cycle", 0, 3'd0);
    tick(); specialHit = 0;
    expectNow("R9 special latched", 1, 3'd6);
    tick(); modemChg = 1;
    expectNow("R3 modem above special", 1, 3'd5);
    tick(); modemChg = 0; flowChg = 1;
    expectNow("R10 flow hidden by special", 1, 3'd6);
    tick(); statusRd = 1;
    expectNow("R9 read on special", 1, 3'd6);
    tick(); statusRd = 0;
    expectNow("R10 flow shown last", 1, 3'd7);
    tick(); irqEn = 4'b0111;
    expectNow("R2 flow masked by enable", 0, 3'd0);
    tick(); irqEn = 4'b1111; flowChg = 0;
    expectNow("R1 idle", 0, 3'd0);
    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule